// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives the six gate signals of a three-phase inverter bridge. A 16-bit up-down timebase counts from zero to a programmed peak and back, so one switching period lasts twice the peak value in clocks. Each phase takes a signed duty value. Zero duty means 50 %. Positive values widen the active pulse of the high-side switch, which is centred on the counter's zero point. Negative values narrow it. At the extremes the pulse saturates cleanly to full ON or full OFF.

The low-side output of each phase is the complement of its high-side output. A programmable dead time delays every turn-on edge on both outputs, so the two switches of a leg never conduct together. Output polarity is set by one input.

New period, duty and dead-time values are captured at the zero point of the counter. In double-update mode they are also captured at the peak. A one-clock sync pulse marks each period. An active-low shutdown input forces all six outputs to their inactive level through purely combinational logic, without waiting for a clock edge.

Top module: `tri_pwm`

## Requirements
- R1: While reset is asserted, every gate output sits at its inactive level (the complement of `activeHigh`) and `syncOut` is low.
- R2: `syncOut` is high for exactly one clock in each period of 2·P clocks, where P is the captured peak value. The counter runs 0, 1, …, P, P−1, …, 1 and then returns to 0.
- R3: A peak value below 2 is treated as 2.
- R4: For each phase, the threshold T equals floor(P/2) plus the signed duty, clamped to the range 0 to P. The high side is active while the count is below T, and it is active throughout when T equals P. With no dead time this gives 2T−1 active clocks per period for 1 ≤ T < P, none for T = 0, and all 2P for T = P.
- R5: With no dead time, each low-side output is active in every clock where its high-side output is not.
- R6: Every inactive-to-active edge on either output of a pair is delayed by the dead time D clocks. Each pulse is therefore shortened by D, and a period holds 2·D clocks in which neither output is active.
- R7: The high-side and low-side outputs of one phase are never active in the same clock.
- R8: In single-update mode (`dblUpdate` = 0), new inputs take effect only from the zero point onward. A period that is already running keeps the values it started with.
- R9: In double-update mode (`dblUpdate` = 1), the inputs are also captured at the peak. The descending half of the current period uses the new values.
- R10: With `activeHigh` = 1, an active output is driven 1. With `activeHigh` = 0, an active output is driven 0.
- R11: While `shutN` is low, every gate output is at its inactive level at once, independent of the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| periodIn | input | 16 | Counter peak P (a period is 2·P clocks) |
| deadIn | input | 16 | Dead time in clocks |
| dutyIn | input | 48 | Signed duty per phase; phase k occupies bits 16k+15:16k |
| dblUpdate | input | 1 | 1 = capture at both zero and peak, 0 = at zero only |
| activeHigh | input | 1 | Output polarity: 1 = active-high |
| shutN | input | 1 | Asynchronous active-low shutdown |
| hiOut | output | 3 | High-side gate outputs, bit k = phase k |
| loOut | output | 3 | Low-side gate outputs, bit k = phase k |
| syncOut | output | 1 | One-clock pulse at each counter zero point |

## Verification
The bench builds the block with its default 16-bit counter and three phases. It programs small peaks (10, and 1 to exercise the floor of 2), so a whole period spans only about twenty clocks. With periods that short, the bench can count the active clocks exactly over each period and compare them with 2T−1 less the dead time. The three phases carry different duty values, so the clamp at 0, the clamp at P and the midrange are all measured in the same run. Short periods also let the bench place a duty change within a known half of the counter sweep, which separates single-update from double-update capture.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture new settings at end of this clock
    logic zero;   // counter is at its zero point
  } strobe_t;
endpackage

// File: rtl/tri_pwm_ctrl.sv
module tri_pwm_ctrl
  import tri_pwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] periodIn,
  input  logic          dblUpdate,
  output strobe_t       stb,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] perAct
);
  localparam logic [CW-1:0] MIN_PER = CW'(2);

  logic          up;
  logic [CW-1:0] effPer;
  logic          atPeak;

  assign effPer   = (periodIn < MIN_PER) ? MIN_PER : periodIn;
  assign atPeak   = up && (cnt >= perAct);
  assign stb.zero = (cnt == '0);
  assign stb.load = stb.zero | (dblUpdate & atPeak);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      up     <= 1'b1;
      perAct <= MIN_PER;
    end else begin
      if (stb.load) perAct <= effPer;
      if (up) begin
        if (cnt >= perAct) begin
          up  <= 1'b0;
          cnt <= cnt - 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (cnt <= CW'(1)) begin
        cnt <= '0;
        up  <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/tri_pwm_dp.sv
module tri_pwm_dp
  import tri_pwm_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NPH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [CW-1:0]     cnt,
  input  logic [CW-1:0]     perAct,
  input  logic [NPH*CW-1:0] dutyIn,
  input  logic [CW-1:0]     deadIn,
  output logic [NPH-1:0]    hiQ,
  output logic [NPH-1:0]    loQ,
  output logic              syncQ
);
  localparam int SW = CW + 2;

  logic [CW-1:0]     deadAct;
  logic [NPH*CW-1:0] dutyAct;
  logic signed [SW-1:0] halfPer;

  assign halfPer = $signed({2'b00, perAct >> 1});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      deadAct <= '0;
      dutyAct <= '0;
      syncQ   <= 1'b0;
    end else begin
      syncQ <= stb.zero;
      if (stb.load) begin
        deadAct <= deadIn;
        dutyAct <= dutyIn;
      end
    end
  end

  for (genvar k = 0; k < NPH; k++) begin : g_phase
    logic signed [SW-1:0] sum;
    logic [CW-1:0]        thr;
    logic                 hiRaw, loRaw, hiGate, loGate;
    logic [CW-1:0]        hiDly, loDly;

    assign sum = halfPer + SW'($signed(dutyAct[k*CW +: CW]));

    always_comb begin
      if (sum < 0)                           thr = '0;
      else if (sum > $signed({2'b00, perAct})) thr = perAct;
      else                                   thr = sum[CW-1:0];
    end

    assign hiRaw  = (thr == perAct) | (cnt < thr);
    assign loRaw  = ~hiRaw;
    assign hiGate = hiRaw && (hiDly >= deadAct);
    assign loGate = loRaw && (loDly >= deadAct);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        hiDly  <= '0;
        loDly  <= '0;
        hiQ[k] <= 1'b0;
        loQ[k] <= 1'b0;
      end else begin
        if (!hiRaw)               hiDly <= '0;
        else if (hiDly < deadAct) hiDly <= hiDly + 1'b1;
        if (!loRaw)               loDly <= '0;
        else if (loDly < deadAct) loDly <= loDly + 1'b1;
        hiQ[k] <= hiGate;
        loQ[k] <= loGate;
      end
    end
  end
endmodule

// File: rtl/tri_pwm.sv
module tri_pwm
  import tri_pwm_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NPH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CW-1:0]     periodIn,
  input  logic [CW-1:0]     deadIn,
  input  logic [NPH*CW-1:0] dutyIn,
  input  logic              dblUpdate,
  input  logic              activeHigh,
  input  logic              shutN,
  output logic [NPH-1:0]    hiOut,
  output logic [NPH-1:0]    loOut,
  output logic              syncOut
);
  strobe_t       stb;
  logic [CW-1:0] cnt, perAct;
  logic [NPH-1:0] hiQ, loQ;

  tri_pwm_ctrl #(.CW(CW)) ctrl_i (
    .clk(clk), .rstN(rstN), .periodIn(periodIn), .dblUpdate(dblUpdate),
    .stb(stb), .cnt(cnt), .perAct(perAct)
  );

  tri_pwm_dp #(.CW(CW), .NPH(NPH)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .cnt(cnt), .perAct(perAct),
    .dutyIn(dutyIn), .deadIn(deadIn), .hiQ(hiQ), .loQ(loQ), .syncQ(syncOut)
  );

  // Shutdown gating is combinational: no clock involved
  assign hiOut = (hiQ & {NPH{shutN}}) ^ {NPH{~activeHigh}};
  assign loOut = (loQ & {NPH{shutN}}) ^ {NPH{~activeHigh}};
endmodule

// File: rtl/tri_pwm_chk.sv
module tri_pwm_chk #(
  parameter int NPH = 3
) (
  input logic           clk,
  input logic           rstN,
  input logic           activeHigh,
  input logic           shutN,
  input logic [NPH-1:0] hiOut,
  input logic [NPH-1:0] loOut,
  input logic           syncOut
);
  logic [NPH-1:0] hiAct, loAct;
  assign hiAct = ~(hiOut ^ {NPH{activeHigh}});
  assign loAct = ~(loOut ^ {NPH{activeHigh}});

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    (hiAct & loAct) == '0); // R7

  AST_SHDN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !shutN |-> (hiAct == '0 && loAct == '0)); // R11

  AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    syncOut |=> !syncOut); // R2

  AST_RESET_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!syncOut && hiAct == '0 && loAct == '0)); // R1
endmodule

bind tri_pwm tri_pwm_chk #(.NPH(NPH)) chk_i (
  .clk(clk), .rstN(rstN), .activeHigh(activeHigh), .shutN(shutN),
  .hiOut(hiOut), .loOut(loOut), .syncOut(syncOut)
);

// File: tb/tri_pwm_tb_top.sv
module tri_pwm_tb_top;
  localparam int CW  = 16;
  localparam int NPH = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CW-1:0] periodIn = 16'd10;
  logic [CW-1:0] deadIn = '0;
  logic [NPH*CW-1:0] dutyIn = '0;
  logic dblUpdate = 1'b0;
  logic activeHigh = 1'b1;
  logic shutN = 1'b1;
  logic [NPH-1:0] hiOut, loOut;
  logic syncOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int hiCnt [NPH];
  int loCnt [NPH];
  int bothCnt, noneCnt, syncCnt;

  always #2 clk = ~clk;

  tri_pwm #(.CW(CW), .NPH(NPH)) dut_i (
    .clk(clk), .rstN(rstN), .periodIn(periodIn), .deadIn(deadIn),
    .dutyIn(dutyIn), .dblUpdate(dblUpdate), .activeHigh(activeHigh),
    .shutN(shutN), .hiOut(hiOut), .loOut(loOut), .syncOut(syncOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setDuty(input int d0, input int d1, input int d2);
    dutyIn = {CW'(d2), CW'(d1), CW'(d0)};
  endtask

  // Count over 2*P samples; if waitSync, first align to a sync sample
  task automatic measure(input int p, input bit waitSync);
    for (int k = 0; k < NPH; k++) begin hiCnt[k] = 0; loCnt[k] = 0; end
    bothCnt = 0; noneCnt = 0; syncCnt = 0;
    if (waitSync) begin
      @(negedge clk);
      while (!syncOut) @(negedge clk);
    end
    for (int i = 0; i < 2 * p; i++) begin
      @(negedge clk);
      if (syncOut) syncCnt++;
      for (int k = 0; k < NPH; k++) begin
        logic h, l;
        h = (hiOut[k] == activeHigh);
        l = (loOut[k] == activeHigh);
        if (h) hiCnt[k]++;
        if (l) loCnt[k]++;
        if (h && l) bothCnt++;
        if (!h && !l && k == 0) noneCnt++;
      end
    end
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(hiOut == 3'b000 && loOut == 3'b000, "R1 gates off in reset", {hiOut, loOut}, 0);
    check(syncOut == 1'b0, "R1 sync low in reset", syncOut, 0);
    rstN = 1'b1;
  endtask

  task automatic tDutyClamp();
    periodIn = 16'd10; deadIn = '0; dblUpdate = 1'b0;
    setDuty(0, 100, -100);
    measure(10, 1); measure(10, 1);
    check(syncCnt == 1, "R2 one sync per 20 clocks", syncCnt, 1);
    check(hiCnt[0] == 9, "R4 zero duty T=5", hiCnt[0], 9);
    check(hiCnt[1] == 20, "R4 clamp full on", hiCnt[1], 20);
    check(hiCnt[2] == 0, "R4 clamp full off", hiCnt[2], 0);
    check(loCnt[0] == 11 && loCnt[1] == 0 && loCnt[2] == 20, "R5 low side complement",
          loCnt[0], 11);
    check(bothCnt == 0, "R7 no overlap", bothCnt, 0);
    setDuty(4, -4, 5);
    measure(10, 1); measure(10, 1);
    check(hiCnt[0] == 17, "R4 T=9", hiCnt[0], 17);
    check(hiCnt[1] == 1, "R4 T=1", hiCnt[1], 1);
    check(hiCnt[2] == 20, "R4 T=P exactly", hiCnt[2], 20);
  endtask

  task automatic tDead();
    setDuty(0, 0, 0); deadIn = 16'd2;
    measure(10, 1); measure(10, 1);
    check(hiCnt[0] == 7, "R6 high pulse shortened", hiCnt[0], 7);
    check(loCnt[0] == 9, "R6 low pulse shortened", loCnt[0], 9);
    check(noneCnt == 4, "R6 two dead gaps", noneCnt, 4);
    check(bothCnt == 0, "R7 no overlap with dead time", bothCnt, 0);
    deadIn = '0;
  endtask

  task automatic tSingle();
    dblUpdate = 1'b0; setDuty(0, 0, 0);
    measure(10, 1); measure(10, 1);
    setDuty(3, 3, 3);
    measure(10, 0);
    check(hiCnt[0] == 9, "R8 running period keeps old duty", hiCnt[0], 9);
    measure(10, 0);
    check(hiCnt[0] == 15, "R8 next period uses new duty", hiCnt[0], 15);
  endtask

  task automatic tDouble();
    dblUpdate = 1'b1; setDuty(0, 0, 0);
    measure(10, 1); measure(10, 1);
    setDuty(3, 3, 3);
    measure(10, 0);
    check(hiCnt[0] == 12, "R9 peak capture splits period", hiCnt[0], 12);
    measure(10, 0);
    check(hiCnt[0] == 15, "R9 full new period", hiCnt[0], 15);
    dblUpdate = 1'b0;
  endtask

  task automatic tMinPeriod();
    periodIn = 16'd1; setDuty(0, 0, 0);
    measure(2, 1); measure(2, 1); measure(2, 1);
    check(syncCnt == 1, "R3 period floor of 2 (sync per 4)", syncCnt, 1);
    check(hiCnt[0] == 1 && loCnt[0] == 3, "R3 P=2 duty split", hiCnt[0], 1);
    periodIn = 16'd10;
    measure(10, 1); measure(10, 1);
  endtask

  task automatic tPolarity();
    activeHigh = 1'b0; setDuty(0, 0, 0);
    measure(10, 1);
    check(hiCnt[0] == 9, "R10 active-low high side drives 0 for 9", hiCnt[0], 9);
    check(loCnt[0] == 11, "R10 active-low low side", loCnt[0], 11);
    activeHigh = 1'b1;
    measure(10, 1);
    check(hiCnt[0] == 9, "R10 active-high restored", hiCnt[0], 9);
  endtask

  task automatic tShutdown();
    setDuty(100, -100, 0);
    measure(10, 1);
    @(negedge clk);
    shutN = 1'b0;
    #0.5;
    check(hiOut == 3'b000 && loOut == 3'b000, "R11 immediate off active-high",
          {hiOut, loOut}, 0);
    repeat (5) @(negedge clk);
    check(hiOut == 3'b000 && loOut == 3'b000, "R11 held off", {hiOut, loOut}, 0);
    activeHigh = 1'b0;
    #0.5;
    check(hiOut == 3'b111 && loOut == 3'b111, "R11 off level active-low",
          {hiOut, loOut}, 63);
    activeHigh = 1'b1;
    shutN = 1'b1;
    measure(10, 1);
    check(hiCnt[0] == 20 && hiCnt[1] == 0, "R11 recovery after shutdown", hiCnt[0], 20);
  endtask

  initial begin
    tReset();
    tDutyClamp();
    tDead();
    tSingle();
    tDouble();
    tMinPeriod();
    tPolarity();
    tShutdown();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule